// File: doc/BRIEF.md
# Shadowed Nonvolatile Static RAM Controller

This block is a clocked model of a small static RAM, 64 words of 4 bits, paired with a second array of the same size. The second array stands in for nonvolatile backing storage. A host reaches the RAM through a word address, separate data-in and data-out buses, an active-low select and an active-low write enable. The data-out bus carries an enable flag in place of a tri-state driver, and that flag is low whenever the bus would be floating.

Two active-low request pins move the whole array in bulk. A falling edge on the save request copies every RAM word into the backing array. A falling edge on the restore request copies the backing array back into the RAM. A transfer moves one word per clock, in ascending address order, and a busy flag stays high for exactly 64 cycles. Normal reads and writes are allowed only while the block is selected, both request pins are high and no transfer is running.

Top module: `nvShadowRam`

## Requirements
- R1: After reset, busy and dataOutEn are low, and both arrays hold all zeros. A restore issued straight after reset therefore makes every RAM word read as 0.
- R2: On a rising clock edge where csN=0, weN=0, storeN=1, recallN=1 and busy=0, the RAM word at addr takes the value of dataIn.
- R3: On a rising clock edge where csN=0, weN=1, storeN=1, recallN=1 and busy=0, dataOut is loaded with the word at addr and dataOutEn goes high. Both are visible one cycle after the request.
- R4: While csN=1, writes, reads and save or restore requests all have no effect, and dataOutEn is low in the next cycle.
- R5: While storeN or recallN is low, no RAM read or write takes place, even when no transfer is running.
- R6: A falling edge on storeN seen with csN=0 and busy=0 raises busy on the next clock edge. Busy then stays high for exactly 64 cycles while every RAM word is copied into the backing array.
- R7: A falling edge on recallN seen with csN=0 and busy=0 raises busy on the next clock edge. Busy then stays high for exactly 64 cycles while every backing word is copied into the RAM.
- R8: When falling edges on storeN and recallN are seen in the same cycle, only the restore (backing array to RAM) is carried out.
- R9: A falling edge on either request pin while busy=1 is discarded. It does not start a transfer afterwards.
- R10: While busy=1, host writes are dropped, host reads are refused and dataOutEn is low.
- R11: dataOut is 0 whenever dataOutEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low select; high means standby |
| weN | input | 1 | Active-low write enable; high requests a read |
| addr | input | 6 | Host word address |
| dataIn | input | 4 | Write data |
| storeN | input | 1 | Active-low save request, acts on its falling edge |
| recallN | input | 1 | Active-low restore request, acts on its falling edge |
| dataOut | output | 4 | Registered read data, 0 when not driven |
| dataOutEn | output | 1 | High when dataOut carries valid read data |
| busy | output | 1 | High while a bulk transfer runs |

## Verification
The RAM is first filled with an address-dependent pattern. A save followed by overwriting the RAM with the bitwise inverse pattern and then a restore shows whether the copy direction and the per-word addressing are right, because a wrong direction or a wrong word leaves inverted values behind. A restore straight after reset reveals any backing content that is not zero. Writes, reads and edges applied in standby, with a request pin held low, or during a transfer show whether each gating term really blocks access. A simultaneous edge on both request pins shows which transfer wins. A behavioural model that runs alongside the design checks busy, dataOutEn and dataOut on every cycle.

// File: rtl/nvShadowPkg.sv
package nvShadowPkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic ramWrite;   // host write into RAM
    logic ramRead;    // host read from RAM
    logic toRam;      // transfer word backing -> RAM
    logic toShadow;   // transfer word RAM -> backing
  } xferStrobes_t;

endpackage

// File: rtl/nvShadowCtrl.sv
module nvShadowCtrl
  import nvShadowPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              storeN,
  input  logic              recallN,
  output xferStrobes_t      strobes,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic storeSeen, recallSeen;
  logic storeFall, recallFall;
  logic selected, inhibit, accept;
  logic busyQ, dirToRamQ;
  logic [ADDR_W-1:0] cntQ;

  assign selected   = ~csN;
  assign inhibit    = ~storeN | ~recallN;
  assign storeFall  = storeSeen & ~storeN;
  assign recallFall = recallSeen & ~recallN;
  assign accept     = selected & ~busyQ & (storeFall | recallFall);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeSeen  <= 1'b1;
      recallSeen <= 1'b1;
      busyQ      <= 1'b0;
      dirToRamQ  <= 1'b0;
      cntQ       <= '0;
    end else begin
      storeSeen  <= storeN;
      recallSeen <= recallN;
      if (accept) begin
        busyQ     <= 1'b1;
        dirToRamQ <= recallFall;   // restore wins a tie
        cntQ      <= '0;
      end else if (busyQ) begin
        if (cntQ == LAST_ADDR) busyQ <= 1'b0;
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.ramWrite = selected & ~weN & ~inhibit & ~busyQ;
    strobes.ramRead  = selected &  weN & ~inhibit & ~busyQ;
    strobes.toRam    = busyQ &  dirToRamQ;
    strobes.toShadow = busyQ & ~dirToRamQ;
  end

  assign xferAddr = cntQ;
  assign busy     = busyQ;

endmodule

// File: rtl/nvShadowData.sv
module nvShadowData
  import nvShadowPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobes_t      strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] xferAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ramMem    [DEPTH];
  logic [DATA_W-1:0] shadowMem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hostHit, xferHit;
    assign hostHit = (hostAddr == ADDR_W'(w));
    assign xferHit = (xferAddr == ADDR_W'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ramMem[w] <= '0;
      end else if (strobes.toRam && xferHit) begin
        ramMem[w] <= shadowMem[w];
      end else if (strobes.ramWrite && hostHit) begin
        ramMem[w] <= dataIn;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowMem[w] <= '0;
      end else if (strobes.toShadow && xferHit) begin
        shadowMem[w] <= ramMem[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataOutEn <= 1'b0;
    end else if (strobes.ramRead) begin
      dataOut   <= ramMem[hostAddr];
      dataOutEn <= 1'b1;
    end else begin
      dataOut   <= '0;
      dataOutEn <= 1'b0;
    end
  end

endmodule

// File: rtl/nvShadowRam.sv
module nvShadowRam
  import nvShadowPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              storeN,
  input  logic              recallN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              busy
);

  xferStrobes_t      strobes;
  logic [ADDR_W-1:0] xferAddr;

  nvShadowCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .weN      (weN),
    .storeN   (storeN),
    .recallN  (recallN),
    .strobes  (strobes),
    .xferAddr (xferAddr),
    .busy     (busy)
  );

  nvShadowData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostAddr  (addr),
    .xferAddr  (xferAddr),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

endmodule

// File: rtl/nvShadowChecker.sv
module nvShadowChecker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              storeN,
  input logic              recallN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;

  int unsigned runLen;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) runLen <= 0;
    else                runLen <= runLen + 1;
  end

  AST_STANDBY_NO_OE: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !dataOutEn);                                          // R4
  AST_INHIBIT_NO_OE: assert property (@(posedge clk) disable iff (!rstN)
    (!storeN || !recallN) |=> !dataOutEn);                        // R5
  AST_BUSY_NO_OE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !dataOutEn);                                         // R10
  AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> dataOut == '0);                                // R11
  AST_SAVE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !csN && $fell(storeN)) |=> busy);                   // R6
  AST_RESTORE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !csN && $fell(recallN)) |=> busy);                  // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runLen < DEPTH - 1) |=> busy);                       // R6
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runLen == DEPTH - 1) |=> !busy);                     // R7

endmodule

bind nvShadowRam nvShadowChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .storeN    (storeN),
  .recallN   (recallN),
  .dataOut   (dataOut),
  .dataOutEn (dataOutEn),
  .busy      (busy)
);

// File: tb/test_nvShadowRam.sv
`timescale 1ns/1ps
module test_nvShadowRam;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, weN = 1'b1, storeN = 1'b1, recallN = 1'b1;
  logic [5:0] addr = '0;
  logic [3:0] dataIn = '0;
  logic [3:0] dataOut;
  logic       dataOutEn, busy;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nvShadowRam i_nvShadowRam (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .storeN(storeN), .recallN(recallN),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .busy(busy)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mRam[64];
  int mSh[64];
  bit mBusy, mDir, mPs, mPr, mEn;
  int mCnt, mOut;
  bit sel, inh, fS, fR;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      foreach (mRam[i]) begin mRam[i] = 0; mSh[i] = 0; end
      mBusy = 0; mDir = 0; mCnt = 0; mPs = 1; mPr = 1; mEn = 0; mOut = 0;
    end else begin
      sel = !csN; inh = !storeN || !recallN;
      fS = mPs && !storeN; fR = mPr && !recallN;
      if (mBusy) begin
        if (mDir) mRam[mCnt] = mSh[mCnt];
        else      mSh[mCnt]  = mRam[mCnt];
      end
      mEn  = sel && weN && !inh && !mBusy;
      mOut = mEn ? mRam[addr] : 0;
      if (sel && !weN && !inh && !mBusy) mRam[addr] = int'(dataIn);
      if (sel && !mBusy && (fS || fR)) begin
        mBusy = 1; mDir = fR; mCnt = 0;
      end else if (mBusy) begin
        if (mCnt == 63) mBusy = 0;
        mCnt++;
      end
      mPs = storeN; mPr = recallN;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(busy == mBusy, "R6 busy vs model", int'(busy), int'(mBusy));
      chk(dataOutEn == mEn, "R10 dataOutEn vs model", int'(dataOutEn), int'(mEn));
      chk(int'(dataOut) == mOut, "R3 dataOut vs model", int'(dataOut), mOut);
      chk(dataOutEn || dataOut == 0, "R11 dataOut idle zero", int'(dataOut), 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic int pat(int a);
    return (a * 5 + 3) & 15;
  endfunction

  task automatic writeWord(int a, int d);
    @(negedge clk);
    csN = 0; weN = 0; addr = 6'(a); dataIn = 4'(d);
    @(negedge clk);
    csN = 1; weN = 1;
  endtask

  task automatic readCheck(int a, int exp, string tag);
    @(negedge clk);
    csN = 0; weN = 1; addr = 6'(a);
    @(negedge clk);
    chk(dataOutEn == 1'b1, tag, int'(dataOutEn), 1);
    chk(int'(dataOut) == exp, tag, int'(dataOut), exp);
    csN = 1;
  endtask

  task automatic pulse(bit doStore, bit doRecall);
    @(negedge clk);
    csN = 0; weN = 1; storeN = !doStore; recallN = !doRecall;
    @(negedge clk);
    storeN = 1; recallN = 1; csN = 1;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    errors++; checks++;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy at reset", int'(busy), 0);
    chk(dataOutEn == 0, "R1 dataOutEn at reset", int'(dataOutEn), 0);
    rstN = 1;

    // R1 + R7: backing array is zero after reset
    writeWord(9, 5);
    pulse(0, 1); waitIdle();
    readCheck(9, 0, "R1 restore of reset backing");
    readCheck(40, 0, "R7 restore of reset backing");

    // R2 / R3: fill and read back
    for (int i = 0; i < 64; i++) writeWord(i, pat(i));
    readCheck(0, pat(0), "R2 write/read addr 0");
    readCheck(63, pat(63), "R3 read addr 63");
    readCheck(22, pat(22), "R3 read addr 22");

    // R6: save, busy length 64
    pulse(1, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 64, "R6 busy length", n, 64);
    for (int i = 0; i < 64; i++) writeWord(i, (~pat(i)) & 15);
    readCheck(17, (~pat(17)) & 15, "R2 inverse write");
    pulse(0, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 64, "R7 busy length", n, 64);
    readCheck(0, pat(0), "R7 restored addr 0");
    readCheck(17, pat(17), "R7 restored addr 17");
    readCheck(63, pat(63), "R7 restored addr 63");

    // R4: standby ignores everything
    @(negedge clk);
    csN = 1; weN = 0; addr = 4; dataIn = 0;
    @(negedge clk);
    weN = 1; storeN = 0;
    chk(dataOutEn == 0, "R4 no output in standby", int'(dataOutEn), 0);
    @(negedge clk);
    chk(busy == 0, "R4 save ignored in standby", int'(busy), 0);
    storeN = 1;
    readCheck(4, pat(4), "R4 standby write dropped");

    // R5: request pin held low blocks access
    @(negedge clk);
    csN = 0; storeN = 0;
    @(negedge clk);
    csN = 1;
    waitIdle();
    @(negedge clk);
    csN = 0; weN = 0; addr = 4; dataIn = 0;
    @(negedge clk);
    weN = 1;
    @(negedge clk);
    chk(dataOutEn == 0, "R5 read blocked while storeN low", int'(dataOutEn), 0);
    csN = 1; storeN = 1;
    readCheck(4, pat(4), "R5 write blocked while storeN low");

    // R8: both edges together, restore wins
    writeWord(10, (~pat(10)) & 15);
    pulse(1, 1); waitIdle();
    readCheck(10, pat(10), "R8 restore priority");

    // R9 / R10: requests and access during a transfer
    pulse(1, 0);
    writeWord(30, (~pat(30)) & 15);
    @(negedge clk);
    csN = 0; weN = 1; addr = 30;
    @(negedge clk);
    chk(dataOutEn == 0, "R10 read refused while busy", int'(dataOutEn), 0);
    recallN = 0;
    @(negedge clk);
    recallN = 1; csN = 1;
    waitIdle();
    @(negedge clk);
    @(negedge clk);
    chk(busy == 0, "R9 request while busy dropped", int'(busy), 0);
    readCheck(30, pat(30), "R10 write dropped while busy");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule